// File: doc/BRIEF.md
# Adaptive Transmit Start Threshold Controller

This block sits beside a transmit FIFO. It decides how many bytes must be queued before the transmitter begins sending a frame. It reads the transmit status queue one entry per cycle and pops each entry it accepts. Every accepted entry falls into exactly one of four outcomes:

- excessive collisions
- FIFO underrun
- jabber
- clean completion

The outcome drives two registers. The first is a base threshold. The second is a run counter of clean completions.

A frame request arrives with its byte length. The block answers one cycle later with a start threshold: a quarter of the length plus the current base. Underruns make the base grow, which makes later frames wait for more data. The base grows only when the link has not had a long enough run of good frames since the previous underrun. The run counter wraps modulo its size, so a very long good run can look short again.

Besides the threshold, the block emits one-cycle pulses toward the surrounding logic:

- an error pulse, for the error statistics
- a collision pulse, for the collision statistics
- a controller reset request
- a transmitter re-enable
- a clear of the transmit-stalled flag

The reset sequence, the statistics counters and the FIFO data path belong to other blocks.

Top module: `txStartAdapt`

## Requirements
- R1: After the asynchronous active-low reset `rstN`, the base threshold is 20 and the good-run counter is 0. All pulse outputs and `startValid` are low.
- R2: A status entry is accepted only in a cycle where `statValid` and `statDone` are both high. In that same cycle `statPop` is high, combinationally. In any other cycle `statPop` is low, and the entry changes no state and raises no pulse.
- R3: A cycle with `frameValid` high causes the next cycle to show `startValid` high and `startThresh` = floor(`frameLen`/4) + base. The base used is the value held in the request cycle.
- R4: An accepted entry with several flags set is classified by priority: `statJabber` first, then `statUnderrun`, then `statMaxColl`. An entry with none of these flags is a clean completion.
- R5: A jabber outcome raises `errPulse` and `resetReq` for one cycle, starting the cycle after acceptance. The base and the counter keep their values.
- R6: An underrun outcome raises `errPulse` and `resetReq` for one cycle. It clears the counter. It adds 20 to the base only if the counter was below 100, and the result never exceeds 1518.
- R7: A max-collision outcome raises `collPulse`, `txReenable` and `stallClear` for one cycle, with no `errPulse` and no `resetReq`. The base and the counter keep their values.
- R8: A clean completion sets the counter to (counter + 1) mod 128 and raises no pulse.
- R9: The base and the counter hold their values across `resetReq`. Only `rstN` returns them to 20 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| statValid | input | 1 | Status queue head is present |
| statDone | input | 1 | Head entry is complete |
| statJabber | input | 1 | Head entry reports jabber |
| statUnderrun | input | 1 | Head entry reports FIFO underrun |
| statMaxColl | input | 1 | Head entry reports excessive collisions |
| statPop | output | 1 | Removes the head entry (same cycle) |
| frameValid | input | 1 | New frame needs a start threshold |
| frameLen | input | LEN_W | Frame length in bytes |
| startValid | output | 1 | `startThresh` is valid this cycle |
| startThresh | output | TH_W | Start threshold for the requested frame |
| errPulse | output | 1 | One error to count |
| collPulse | output | 1 | One collision event to count |
| resetReq | output | 1 | Request to reset the controller |
| txReenable | output | 1 | Re-enable the transmitter |
| stallClear | output | 1 | Clear the transmit-stalled flag |

## Verification
The hardest state to reach from the ports is the good-run counter, which is never output directly. It shows only in whether the next underrun grows the base.

The bench sends runs of clean completions of chosen lengths: 0, 99, 100, 127, 128, 227 and 228. It follows each run with an underrun, then reads the base back through a frame request. This exposes the below-100 decision and the modulo-128 wrap.

The bench also drives a long train of underruns to hit the 1518 ceiling. It sweeps all sixteen flag combinations to check the classification priority and the acceptance gating.

// File: rtl/txStartPkg.sv
package txStartPkg;

  // Classification of one accepted status entry
  typedef enum logic [2:0] {
    OC_NONE,
    OC_JABBER,
    OC_UNDERRUN,
    OC_MAXCOLL,
    OC_GOOD
  } outcomeT;

  // Strobes from control to datapath, valid in the acceptance cycle
  typedef struct packed {
    logic bumpThresh;   // grow base threshold (saturating)
    logic clearCount;   // zero the good-run counter
    logic incCount;     // advance the good-run counter
  } strobeT;

endpackage

// File: rtl/txStartCtl.sv
module txStartCtl
  import txStartPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   statValid,
  input  logic   statDone,
  input  logic   statJabber,
  input  logic   statUnderrun,
  input  logic   statMaxColl,
  input  logic   goodLow,
  output logic   statPop,
  output strobeT strb,
  output logic   errPulse,
  output logic   collPulse,
  output logic   resetReq,
  output logic   txReenable,
  output logic   stallClear
);

  logic    accept;
  outcomeT outcome;

  assign accept  = statValid & statDone;
  assign statPop = accept;

  // Priority classification: jabber, underrun, collisions, good
  always_comb begin
    if (!accept)           outcome = OC_NONE;
    else if (statJabber)   outcome = OC_JABBER;
    else if (statUnderrun) outcome = OC_UNDERRUN;
    else if (statMaxColl)  outcome = OC_MAXCOLL;
    else                   outcome = OC_GOOD;
  end

  always_comb begin
    strb            = '0;
    strb.bumpThresh = (outcome == OC_UNDERRUN) && goodLow;
    strb.clearCount = (outcome == OC_UNDERRUN);
    strb.incCount   = (outcome == OC_GOOD);
  end

  // Side-effect pulses, one cycle after acceptance
  logic errQ, rstQ, collQ, reenQ, stallQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ   <= 1'b0;
      rstQ   <= 1'b0;
      collQ  <= 1'b0;
      reenQ  <= 1'b0;
      stallQ <= 1'b0;
    end else begin
      errQ   <= (outcome == OC_JABBER) || (outcome == OC_UNDERRUN);
      rstQ   <= (outcome == OC_JABBER) || (outcome == OC_UNDERRUN);
      collQ  <= (outcome == OC_MAXCOLL);
      reenQ  <= (outcome == OC_MAXCOLL);
      stallQ <= (outcome == OC_MAXCOLL);
    end
  end

  assign errPulse   = errQ;
  assign resetReq   = rstQ;
  assign collPulse  = collQ;
  assign txReenable = reenQ;
  assign stallClear = stallQ;

  // R2: no accepted entry means no pulse in the following cycle
  a_r2_no_pulse_idle: assert property (@(posedge clk) disable iff (!rstN)
    !statPop |=> (!errPulse && !collPulse && !resetReq));

  // R4: an entry has a single outcome, so error and collision never coincide
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(collPulse && errPulse));

  // R5: a reset request always comes with an error pulse
  a_r5_reset_with_err: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> errPulse);

  // R7: a re-enable comes with the collision pulse and the stall clear
  a_r7_coll_set: assert property (@(posedge clk) disable iff (!rstN)
    txReenable |-> (collPulse && stallClear && !resetReq));

endmodule

// File: rtl/txStartDp.sv
module txStartDp
  import txStartPkg::*;
#(
  parameter int LEN_W       = 11,
  parameter int INIT_THRESH = 20,
  parameter int STEP        = 20,
  parameter int MAX_THRESH  = 1518,
  parameter int GOOD_LIMIT  = 100,
  parameter int GOOD_MOD    = 128,
  localparam int BASE_W     = $clog2(MAX_THRESH + 1),
  localparam int CNT_W      = $clog2(GOOD_MOD),
  localparam int TH_W       = ((LEN_W > BASE_W) ? LEN_W : BASE_W) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic             frameValid,
  input  logic [LEN_W-1:0] frameLen,
  output logic             goodLow,
  output logic             startValid,
  output logic [TH_W-1:0]  startThresh
);

  logic [BASE_W-1:0] baseQ, baseNext;
  logic [BASE_W:0]   bumpSum;
  logic [CNT_W-1:0]  countQ, countNext;

  assign goodLow = (countQ < CNT_W'(GOOD_LIMIT));

  // Saturating step of the base threshold
  always_comb begin
    bumpSum  = {1'b0, baseQ} + (BASE_W + 1)'(STEP);
    baseNext = baseQ;
    if (strb.bumpThresh) begin
      if (bumpSum > (BASE_W + 1)'(MAX_THRESH)) baseNext = BASE_W'(MAX_THRESH);
      else                                     baseNext = bumpSum[BASE_W-1:0];
    end
  end

  // Good-run counter, explicit modulo wrap
  always_comb begin
    countNext = countQ;
    if (strb.clearCount)
      countNext = '0;
    else if (strb.incCount)
      countNext = (countQ == CNT_W'(GOOD_MOD - 1)) ? '0 : countQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= BASE_W'(INIT_THRESH);
      countQ <= '0;
    end else begin
      baseQ  <= baseNext;
      countQ <= countNext;
    end
  end

  // Start threshold for the requested frame, registered
  logic [TH_W-1:0] threshQ;
  logic            tValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      threshQ <= '0;
      tValidQ <= 1'b0;
    end else begin
      tValidQ <= frameValid;
      if (frameValid)
        threshQ <= TH_W'(frameLen >> 2) + TH_W'(baseQ);
    end
  end

  assign startValid  = tValidQ;
  assign startThresh = threshQ;

  // R6: base stays within its initial value and the ceiling
  a_r6_base_range: assert property (@(posedge clk) disable iff (!rstN)
    (baseQ <= BASE_W'(MAX_THRESH)) && (baseQ >= BASE_W'(INIT_THRESH)));

  // R5: base moves only on a bump strobe
  a_r5_base_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.bumpThresh |=> $stable(baseQ));

  // R6: underrun leaves the counter at zero
  a_r6_count_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCount |=> (countQ == '0));

  // R8: counter wraps to zero after its top value
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incCount && !strb.clearCount && countQ == CNT_W'(GOOD_MOD - 1))
      |=> (countQ == '0));

  // R3: each request yields a valid threshold one cycle later
  a_r3_start_valid: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> startValid);

endmodule

// File: rtl/txStartAdapt.sv
module txStartAdapt
  import txStartPkg::*;
#(
  parameter int LEN_W       = 11,
  parameter int INIT_THRESH = 20,
  parameter int STEP        = 20,
  parameter int MAX_THRESH  = 1518,
  parameter int GOOD_LIMIT  = 100,
  parameter int GOOD_MOD    = 128,
  localparam int BASE_W     = $clog2(MAX_THRESH + 1),
  localparam int TH_W       = ((LEN_W > BASE_W) ? LEN_W : BASE_W) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             statValid,
  input  logic             statDone,
  input  logic             statJabber,
  input  logic             statUnderrun,
  input  logic             statMaxColl,
  output logic             statPop,
  input  logic             frameValid,
  input  logic [LEN_W-1:0] frameLen,
  output logic             startValid,
  output logic [TH_W-1:0]  startThresh,
  output logic             errPulse,
  output logic             collPulse,
  output logic             resetReq,
  output logic             txReenable,
  output logic             stallClear
);

  strobeT strb;
  logic   goodLow;

  txStartCtl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .statValid    (statValid),
    .statDone     (statDone),
    .statJabber   (statJabber),
    .statUnderrun (statUnderrun),
    .statMaxColl  (statMaxColl),
    .goodLow      (goodLow),
    .statPop      (statPop),
    .strb         (strb),
    .errPulse     (errPulse),
    .collPulse    (collPulse),
    .resetReq     (resetReq),
    .txReenable   (txReenable),
    .stallClear   (stallClear)
  );

  txStartDp #(
    .LEN_W       (LEN_W),
    .INIT_THRESH (INIT_THRESH),
    .STEP        (STEP),
    .MAX_THRESH  (MAX_THRESH),
    .GOOD_LIMIT  (GOOD_LIMIT),
    .GOOD_MOD    (GOOD_MOD)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .frameValid  (frameValid),
    .frameLen    (frameLen),
    .goodLow     (goodLow),
    .startValid  (startValid),
    .startThresh (startThresh)
  );

endmodule

// File: tb/test_txStartAdapt.sv
`timescale 1ns/100ps
module test_txStartAdapt;

  localparam int LEN_W = 11;
  localparam int TH_W  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic statValid = 1'b0, statDone = 1'b0, statJabber = 1'b0;
  logic statUnderrun = 1'b0, statMaxColl = 1'b0;
  logic statPop;
  logic frameValid = 1'b0;
  logic [LEN_W-1:0] frameLen = '0;
  logic startValid;
  logic [TH_W-1:0] startThresh;
  logic errPulse, collPulse, resetReq, txReenable, stallClear;

  always #2 clk = ~clk;

  txStartAdapt i_txStartAdapt (
    .clk(clk), .rstN(rstN),
    .statValid(statValid), .statDone(statDone), .statJabber(statJabber),
    .statUnderrun(statUnderrun), .statMaxColl(statMaxColl), .statPop(statPop),
    .frameValid(frameValid), .frameLen(frameLen),
    .startValid(startValid), .startThresh(startThresh),
    .errPulse(errPulse), .collPulse(collPulse), .resetReq(resetReq),
    .txReenable(txReenable), .stallClear(stallClear)
  );

  int total = 0;
  int fails = 0;
  int mBase = 20;
  int mCount = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hwReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mBase = 20;
    mCount = 0;
  endtask

  // Request a threshold and compare it with the model
  task automatic probe(input int len, input string tag);
    @(negedge clk);
    frameValid = 1'b1;
    frameLen = LEN_W'(len);
    @(negedge clk);
    frameValid = 1'b0;
    check(startValid === 1'b1, tag, int'(startValid), 1);
    check(int'(startThresh) == len / 4 + mBase, tag, int'(startThresh), len / 4 + mBase);
  endtask

  // One status presentation; kind: 0 ignored, 1 jabber, 2 underrun, 3 coll, 4 good
  task automatic sendStat(input bit v, input bit d, input bit j, input bit u,
                          input bit c, input bit doCheck, input string tag);
    int kind;
    bit expErr, expColl;
    if (!(v && d))  kind = 0;
    else if (j)     kind = 1;
    else if (u)     kind = 2;
    else if (c)     kind = 3;
    else            kind = 4;
    @(negedge clk);
    statValid = v; statDone = d; statJabber = j; statUnderrun = u; statMaxColl = c;
    #1;
    if (doCheck) check(statPop === (v && d), {tag, " pop"}, int'(statPop), int'(v && d));
    @(negedge clk);
    statValid = 0; statDone = 0; statJabber = 0; statUnderrun = 0; statMaxColl = 0;
    expErr  = (kind == 1) || (kind == 2);
    expColl = (kind == 3);
    if (doCheck) begin
      check(errPulse === expErr, {tag, " err"}, int'(errPulse), int'(expErr));
      check(resetReq === expErr, {tag, " rst"}, int'(resetReq), int'(expErr));
      check(collPulse === expColl && txReenable === expColl && stallClear === expColl,
            {tag, " coll"}, int'({collPulse, txReenable, stallClear}), expColl ? 7 : 0);
    end
    if (kind == 2) begin
      if (mCount < 100) mBase = (mBase + 20 > 1518) ? 1518 : mBase + 20;
      mCount = 0;
    end else if (kind == 4) begin
      mCount = (mCount + 1) % 128;
    end
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  int runs[9] = '{0, 50, 99, 100, 127, 128, 200, 227, 228};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(startValid === 1'b0 && errPulse === 1'b0 && resetReq === 1'b0 &&
          collPulse === 1'b0 && statPop === 1'b0, "R1 outputs in reset", 1, 0);
    rstN = 1'b1;
    probe(0, "R1 base after reset");

    // R3: threshold arithmetic over small and large lengths
    for (int l = 0; l < 24; l++) probe(l, "R3 small length");
    for (int l = 2040; l < 2048; l++) probe(l, "R3 large length");

    // R2: entries without valid or without done are ignored
    sendStat(1, 0, 1, 1, 1, 1, "R2 not done");
    sendStat(0, 1, 0, 1, 0, 1, "R2 not valid");
    probe(64, "R2 base untouched");

    // R4: all flag combinations, base checked after each
    for (int i = 0; i < 16; i++) begin
      sendStat(1, i[3], i[2], i[1], i[0], 1, "R4 priority sweep");
      probe(100, "R4 base after sweep entry");
    end

    // R5: jabber keeps base and counter; R9: state survives resetReq
    hwReset();
    sendStat(1, 1, 0, 1, 0, 1, "R6 first underrun");
    sendStat(1, 1, 1, 1, 1, 1, "R5 jabber");
    probe(8, "R9 base kept across reset request");
    // R7: collision keeps base and counter
    sendStat(1, 1, 0, 0, 1, 1, "R7 max collisions");
    probe(8, "R7 base kept");

    // R6/R8: good-run lengths then an underrun reveal the counter
    foreach (runs[k]) begin
      hwReset();
      for (int n = 0; n < runs[k]; n++) sendStat(1, 1, 0, 0, 0, 0, "R8 run");
      sendStat(1, 1, 0, 1, 0, 1, "R6 underrun after run");
      probe(40, "R8 counter threshold decision");
    end

    // R6: ceiling at 1518
    hwReset();
    for (int n = 0; n < 80; n++) sendStat(1, 1, 0, 1, 0, 0, "R6 climb");
    probe(2047, "R6 ceiling");

    // R9: counter survives resetReq; only rstN clears it
    hwReset();
    for (int n = 0; n < 100; n++) sendStat(1, 1, 0, 0, 0, 0, "R9 run");
    sendStat(1, 1, 1, 0, 0, 1, "R9 jabber mid run");
    sendStat(1, 1, 0, 1, 0, 1, "R9 underrun keeps base");
    probe(12, "R9 counter held across reset request");
    hwReset();
    probe(12, "R1 base after second reset");

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule